// File: doc/BRIEF.md
# NAND Flash Bus Cycle Bridge

This block connects a simple request/done host port to an 8-bit parallel NAND flash bus. A host access that targets the bank window becomes one NAND bus cycle. Which kind of cycle it becomes depends on the access offset. If the address-window bit is set, the write is an address-latch cycle. If only the command-window bit is set, the write is a command-latch cycle. Any other offset gives a plain data cycle. Each bus cycle has a setup phase, a write or read strobe of programmable length, and a hold phase. While a bus cycle is in progress the host port reports not-ready.

A second, small register space holds three registers:

- a chip control word, with one enable bit and one assert bit per attached chip;
- a read-only status word that returns the synchronized ready/busy pin;
- a strobe width register.

Software selects flash commands, addresses and data by writing into the matching sub-window, and frames each flash operation by asserting the chip-enable of the target chip.

Top module: `nand_cycle_bridge`

## Requirements
- R1: A bank-window write whose offset has bit 16 set drives a cycle with ALE high, CLE low and the low 8 bits of the write data on the bus.
- R2: A bank-window write with offset bit 15 set and bit 16 clear drives a cycle with CLE high and ALE low.
- R3: A bank-window access with offset bits 15 and 16 both clear is a data cycle with CLE and ALE both low, for writes and for reads.
- R4: When both offset bits 15 and 16 are set, only ALE is driven. CLE and ALE are never high in the same clock.
- R5: Given a strobe width value W, a write holds the write strobe low for exactly W+1 clocks and leaves the read strobe high. A read holds the read strobe low for exactly W+1 clocks and leaves the write strobe high.
- R6: A bank read returns, in the low 8 bits of the host read data, the bus value present during the final clock of the read strobe, which is the value at the strobe's rising edge.
- R7: CLE, ALE and the driven data stay constant while a strobe is low. The data-drive enable is high for a write cycle and low during a read strobe.
- R8: The chip control register sits at register offset 0. Bit 2n enables chip n and bit 2n+1 asserts it. The active-low chip enable of chip n goes low only when both bits are set, and the register reads back as written.
- R9: Writing zero to the chip control register returns every chip enable output to high.
- R10: The ready/busy pin passes through two flip-flops. A status read at register offset 4 returns it in bit 0. A read accepted on the first clock after a pin change still returns the old level, and the next read returns the new level.
- R11: The strobe width register sits at register offset 8. It is 4 bits wide, resets to 2, reads back as written, and sets W for all later bus cycles.
- R12: The host ready output is low from the clock after a bank access is accepted until that cycle ends. Each access produces a done pulse exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, taken when host_ready is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_reg_sel | input | 1 | 1 = register space, 0 = bank window |
| host_addr | input | BANK_AW (17) | Offset within the selected space |
| host_wdata | input | HOST_DW (32) | Write data |
| host_ready | output | 1 | Bridge can accept a request |
| host_done | output | 1 | One-clock completion pulse |
| host_rdata | output | HOST_DW (32) | Read data, valid with host_done |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Bus data out |
| nand_dq_oe | output | 1 | Bus data drive enable |
| nand_dq_i | input | 8 | Bus data in |
| nand_ce_n | output | NCHIPS (4) | Chip enables, active low |
| nand_rb | input | 1 | Ready/busy pin (1 = ready) |

## Verification
Two functions can fall in the same cycle.

The first is the command and address decode. An offset with both window bits set makes both decodes hit in one access. The bench issues such a write and judges that the strobe shows only ALE high, and that no clock ever showed CLE and ALE together.

The second is a status read taken in the very clock where the ready/busy pin changes. The bench moves the pin and issues the read on the same edge. It expects the old level from that read and the new level from the next one, which shows the two-stage delay.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;

  typedef enum logic [1:0] {
    KIND_DATA = 2'b00,
    KIND_CMD  = 2'b01,
    KIND_ADDR = 2'b10
  } cyc_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_SETUP  = 2'b01,
    ST_STROBE = 2'b10,
    ST_HOLD   = 2'b11
  } seq_state_t;

  localparam logic [1:0] REG_IDX_CTRL = 2'd0;
  localparam logic [1:0] REG_IDX_STAT = 2'd1;
  localparam logic [1:0] REG_IDX_TIME = 2'd2;

  // The address window wins over the command window when both hit.
  function automatic cyc_kind_t decode_kind(input logic addr_hit, input logic cmd_hit);
    if (addr_hit)     return KIND_ADDR;
    else if (cmd_hit) return KIND_CMD;
    else              return KIND_DATA;
  endfunction

endpackage

// File: rtl/nand_sync_chain.sv
module nand_sync_chain #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q <= {STAGES{RST_VAL}};
    else     stage_q <= {stage_q[STAGES-2:0], din};
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/nand_chip_regs.sv
module nand_chip_regs #(
  parameter int unsigned NCHIPS   = 4,
  parameter int unsigned PW_W     = 4,
  parameter int unsigned PW_RESET = 2,
  localparam int unsigned CTRL_W  = 2 * NCHIPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic              time_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic [PW_W-1:0]   time_wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [PW_W-1:0]   pulse_w,
  output logic [NCHIPS-1:0] ce_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      pulse_w <= PW_W'(PW_RESET);
    end else begin
      if (ctrl_we) ctrl_q  <= ctrl_wdata;
      if (time_we) pulse_w <= time_wdata;
    end
  end

  // One registered chip enable per chip: low only when enable and assert are both set.
  for (genvar n = 0; n < NCHIPS; n++) begin : g_ce
    always_ff @(posedge clk) begin
      if (rst) ce_n[n] <= 1'b1;
      else     ce_n[n] <= ~(ctrl_q[2*n] & ctrl_q[2*n+1]);
    end
  end
endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nand_bridge_pkg::*;
#(
  parameter int unsigned PW_W = 4,
  parameter int unsigned DQ_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            is_write,
  input  cyc_kind_t       kind,
  input  logic [DQ_W-1:0] wdata,
  input  logic [PW_W-1:0] pulse_w,
  input  logic [DQ_W-1:0] dq_i,
  output logic            busy,
  output logic            done,
  output logic [DQ_W-1:0] rdata,
  output logic            cle,
  output logic            ale,
  output logic            we_n,
  output logic            re_n,
  output logic [DQ_W-1:0] dq_o,
  output logic            dq_oe
);
  seq_state_t      state;
  logic [PW_W-1:0] cnt;
  logic            wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      wr_q  <= 1'b0;
      cle   <= 1'b0;
      ale   <= 1'b0;
      we_n  <= 1'b1;
      re_n  <= 1'b1;
      dq_o  <= '0;
      dq_oe <= 1'b0;
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            wr_q  <= is_write;
            cle   <= (kind == KIND_CMD);
            ale   <= (kind == KIND_ADDR);
            dq_o  <= wdata;
            dq_oe <= is_write;
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          cnt <= pulse_w;
          if (wr_q) we_n <= 1'b0;
          else      re_n <= 1'b0;
          state <= ST_STROBE;
        end
        ST_STROBE: begin
          if (cnt == '0) begin
            we_n <= 1'b1;
            re_n <= 1'b1;
            if (!wr_q) rdata <= dq_i;   // sampled on the strobe's rising edge
            state <= ST_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          cle   <= 1'b0;
          ale   <= 1'b0;
          dq_oe <= 1'b0;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/nand_cycle_bridge.sv
module nand_cycle_bridge
  import nand_bridge_pkg::*;
#(
  parameter int unsigned NCHIPS   = 4,
  parameter int unsigned HOST_DW  = 32,
  parameter int unsigned BANK_AW  = 17,
  parameter int unsigned ALE_BIT  = 16,
  parameter int unsigned CLE_BIT  = 15,
  parameter int unsigned PW_W     = 4,
  parameter int unsigned PW_RESET = 2,
  localparam int unsigned DQ_W    = 8,
  localparam int unsigned CTRL_W  = 2 * NCHIPS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_req,
  input  logic               host_we,
  input  logic               host_reg_sel,
  input  logic [BANK_AW-1:0] host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic               host_ready,
  output logic               host_done,
  output logic [HOST_DW-1:0] host_rdata,
  output logic               nand_cle,
  output logic               nand_ale,
  output logic               nand_we_n,
  output logic               nand_re_n,
  output logic [DQ_W-1:0]    nand_dq_o,
  output logic               nand_dq_oe,
  input  logic [DQ_W-1:0]    nand_dq_i,
  output logic [NCHIPS-1:0]  nand_ce_n,
  input  logic               nand_rb
);
  logic              accept, bank_start, reg_acc;
  logic [1:0]        reg_idx;
  logic              ctrl_we, time_we;
  logic [CTRL_W-1:0] ctrl_q;
  logic [PW_W-1:0]   pulse_w;
  logic              rb_sync;
  logic              seq_busy, seq_done;
  logic [DQ_W-1:0]   seq_rdata;
  logic              reg_done;
  logic [HOST_DW-1:0] reg_mux, reg_rdata;
  cyc_kind_t         kind;
  logic              unused_bits;

  assign host_ready = ~seq_busy;
  assign accept     = host_req & host_ready;
  assign bank_start = accept & ~host_reg_sel;
  assign reg_acc    = accept & host_reg_sel;
  assign reg_idx    = host_addr[3:2];
  assign ctrl_we    = reg_acc & host_we & (reg_idx == REG_IDX_CTRL);
  assign time_we    = reg_acc & host_we & (reg_idx == REG_IDX_TIME);
  assign kind       = decode_kind(host_addr[ALE_BIT], host_addr[CLE_BIT]);
  assign unused_bits = ^{host_addr, host_wdata};

  nand_chip_regs #(
    .NCHIPS(NCHIPS), .PW_W(PW_W), .PW_RESET(PW_RESET)
  ) i_regs (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .time_we    (time_we),
    .ctrl_wdata (host_wdata[CTRL_W-1:0]),
    .time_wdata (host_wdata[PW_W-1:0]),
    .ctrl_q     (ctrl_q),
    .pulse_w    (pulse_w),
    .ce_n       (nand_ce_n)
  );

  nand_sync_chain #(.STAGES(2), .RST_VAL(1'b1)) i_rb_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (nand_rb),
    .dout (rb_sync)
  );

  nand_strobe_seq #(.PW_W(PW_W), .DQ_W(DQ_W)) i_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (bank_start),
    .is_write (host_we),
    .kind     (kind),
    .wdata    (host_wdata[DQ_W-1:0]),
    .pulse_w  (pulse_w),
    .dq_i     (nand_dq_i),
    .busy     (seq_busy),
    .done     (seq_done),
    .rdata    (seq_rdata),
    .cle      (nand_cle),
    .ale      (nand_ale),
    .we_n     (nand_we_n),
    .re_n     (nand_re_n),
    .dq_o     (nand_dq_o),
    .dq_oe    (nand_dq_oe)
  );

  always_comb begin
    reg_mux = '0;
    case (reg_idx)
      REG_IDX_CTRL: reg_mux[CTRL_W-1:0] = ctrl_q;
      REG_IDX_STAT: reg_mux[0]          = rb_sync;
      REG_IDX_TIME: reg_mux[PW_W-1:0]   = pulse_w;
      default:      reg_mux             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_done  <= 1'b0;
      reg_rdata <= '0;
    end else begin
      reg_done <= reg_acc;
      if (reg_acc && !host_we) reg_rdata <= reg_mux;
    end
  end

  assign host_done  = reg_done | seq_done;
  assign host_rdata = seq_done ? {{(HOST_DW-DQ_W){1'b0}}, seq_rdata} : reg_rdata;
endmodule

// File: rtl/nand_cycle_bridge_chk.sv
module nand_cycle_bridge_chk #(
  parameter int unsigned NCHIPS = 4,
  localparam int unsigned CTRL_W = 2 * NCHIPS
) (
  input logic              clk,
  input logic              rst,
  input logic              cle,
  input logic              ale,
  input logic              we_n,
  input logic              re_n,
  input logic [7:0]        dq_o,
  input logic              dq_oe,
  input logic              host_ready,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [NCHIPS-1:0] ce_n
);
  p_cle_ale_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(cle && ale));

  p_single_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));

  p_bus_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (!we_n || !re_n) |-> ($stable(cle) && $stable(ale) && $stable(dq_o)));

  p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (rst)
    !re_n |-> !dq_oe);

  p_busy_in_strobe_r12: assert property (@(posedge clk) disable iff (rst)
    (!we_n || !re_n) |-> !host_ready);

  for (genvar n = 0; n < NCHIPS; n++) begin : g_ce_chk
    p_ce_gate_r8: assert property (@(posedge clk) disable iff (rst)
      !ce_n[n] |-> $past(ctrl_q[2*n] && ctrl_q[2*n+1]));
  end
endmodule

bind nand_cycle_bridge nand_cycle_bridge_chk #(.NCHIPS(NCHIPS)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .cle        (nand_cle),
  .ale        (nand_ale),
  .we_n       (nand_we_n),
  .re_n       (nand_re_n),
  .dq_o       (nand_dq_o),
  .dq_oe      (nand_dq_oe),
  .host_ready (host_ready),
  .ctrl_q     (ctrl_q),
  .ce_n       (nand_ce_n)
);

// File: tb/test_nand_cycle_bridge.sv
module test_nand_cycle_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0, host_we = 1'b0, host_reg_sel = 1'b0;
  logic [16:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ready, host_done;
  logic [31:0] host_rdata;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_o, nand_dq_i;
  logic [3:0]  nand_ce_n;
  logic        nand_rb = 1'b1;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  nand_cycle_bridge i_nand_cycle_bridge (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_reg_sel(host_reg_sel), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ready(host_ready), .host_done(host_done), .host_rdata(host_rdata),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
    .nand_dq_i(nand_dq_i), .nand_ce_n(nand_ce_n), .nand_rb(nand_rb)
  );

  // Flash model: the read value steps by one on every clock the read strobe is low.
  localparam logic [7:0] RD_BASE = 8'h40;
  int re_cnt = 0;
  assign nand_dq_i = RD_BASE + 8'(re_cnt);

  // Strobe monitor, sampled on the falling edge.
  int we_lo = 0, re_lo = 0, we_len = 0, re_len = 0;
  logic f_cle, f_ale, f_oe;
  logic [7:0] f_dq;
  bit stab_err = 0, overlap = 0, both_strobes = 0;

  always @(negedge clk) begin
    if (nand_cle && nand_ale) overlap = 1;
    if (!nand_we_n && !nand_re_n) both_strobes = 1;
    if (!nand_re_n) re_cnt = re_cnt + 1; else re_cnt = 0;
    if (!nand_we_n || !nand_re_n) begin
      if (we_lo == 0 && re_lo == 0) begin
        f_cle = nand_cle; f_ale = nand_ale; f_dq = nand_dq_o; f_oe = nand_dq_oe;
      end else if (nand_cle != f_cle || nand_ale != f_ale || nand_dq_o != f_dq)
        stab_err = 1;
    end
    if (!nand_we_n) we_lo++;
    else if (we_lo != 0) begin we_len = we_lo; we_lo = 0; end
    if (!nand_re_n) re_lo++;
    else if (re_lo != 0) begin re_len = re_lo; re_lo = 0; end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // One host access; reports read data and whether ready dropped after acceptance.
  task automatic access(input logic rs, input logic we, input logic [16:0] a,
                        input logic [31:0] d, output logic [31:0] q, output logic rdy_after);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_req = 1; host_reg_sel = rs; host_we = we; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 0;
    rdy_after = host_ready;
    while (!host_done) @(negedge clk);
    q = host_rdata;
    @(negedge clk);
    check("R12 done pulse width", {31'b0, host_done}, 32'd0);
  endtask

  task automatic bank_write(input string req, input logic [16:0] a, input logic [7:0] d,
                            input logic exp_cle, input logic exp_ale, input int exp_len);
    logic [31:0] q; logic ra;
    int re_before;
    re_before = re_len;
    stab_err = 0;
    access(1'b0, 1'b1, a, {24'h0, d}, q, ra);
    check({req, " CLE"}, {31'b0, f_cle}, {31'b0, exp_cle});
    check({req, " ALE"}, {31'b0, f_ale}, {31'b0, exp_ale});
    check({req, " data"}, {24'b0, f_dq}, {24'b0, d});
    check("R5 write strobe length", we_len, exp_len);
    check("R5 no read strobe on write", re_len, re_before);
    check("R7 drive enable on write", {31'b0, f_oe}, 32'd1);
    check("R7 stable during strobe", {31'b0, stab_err}, 32'd0);
    check("R12 ready low in cycle", {31'b0, ra}, 32'd0);
  endtask

  task automatic bank_read(input int w);
    logic [31:0] q; logic ra;
    int we_before;
    we_before = we_len;
    stab_err = 0;
    access(1'b0, 1'b0, 17'h00000, 32'h0, q, ra);
    check("R6 read capture", q, {24'b0, RD_BASE + 8'(w + 1)});
    check("R5 read strobe length", re_len, w + 1);
    check("R5 no write strobe on read", we_len, we_before);
    check("R3 read CLE/ALE low", {30'b0, f_cle, f_ale}, 32'd0);
    check("R7 no drive on read", {31'b0, f_oe}, 32'd0);
    check("R12 ready low in read", {31'b0, ra}, 32'd0);
  endtask

  task automatic reg_write(input logic [16:0] a, input logic [31:0] d);
    logic [31:0] q; logic ra;
    access(1'b1, 1'b1, a, d, q, ra);
  endtask

  task automatic reg_read(input logic [16:0] a, output logic [31:0] q);
    logic ra;
    access(1'b1, 1'b0, a, 32'h0, q, ra);
  endtask

  task automatic t_reset();
    logic [31:0] q;
    check("R12 ready after reset", {31'b0, host_ready}, 32'd1);
    check("R5 strobes idle", {30'b0, nand_we_n, nand_re_n}, 32'd3);
    check("R4 CLE/ALE idle", {30'b0, nand_cle, nand_ale}, 32'd0);
    check("R8 chips off after reset", {28'b0, nand_ce_n}, 32'hF);
    reg_read(17'h8, q);
    check("R11 width reset value", q, 32'd2);
    reg_read(17'h4, q);
    check("R10 status ready", q, 32'd1);
  endtask

  task automatic t_cycles();
    bank_write("R2 command", 17'h08000, 8'h70, 1'b1, 1'b0, 3);
    bank_write("R1 address", 17'h10000, 8'h3C, 1'b0, 1'b1, 3);
    bank_write("R3 data write", 17'h00004, 8'hE1, 1'b0, 1'b0, 3);
    bank_write("R4 both window bits", 17'h18000, 8'h5A, 1'b0, 1'b1, 3);
    check("R4 never both latches", {31'b0, overlap}, 32'd0);
    check("R5 never both strobes", {31'b0, both_strobes}, 32'd0);
    bank_read(2);
  endtask

  task automatic t_width();
    logic [31:0] q;
    reg_write(17'h8, 32'd5);
    reg_read(17'h8, q);
    check("R11 width readback", q, 32'd5);
    bank_write("R11 wide write", 17'h08000, 8'h90, 1'b1, 1'b0, 6);
    bank_read(5);
    reg_write(17'h8, 32'd0);
    bank_write("R11 minimum write", 17'h10000, 8'h01, 1'b0, 1'b1, 1);
    bank_read(0);
    reg_write(17'h8, 32'd2);
  endtask

  task automatic ctrl_case(input logic [7:0] v, input logic [3:0] exp_ce, input string req);
    logic [31:0] q;
    reg_write(17'h0, {24'b0, v});
    @(negedge clk); @(negedge clk);
    check(req, {28'b0, nand_ce_n}, {28'b0, exp_ce});
    reg_read(17'h0, q);
    check("R8 control readback", q, {24'b0, v});
  endtask

  task automatic t_chips();
    ctrl_case(8'h03, 4'b1110, "R8 chip0 enabled and asserted");
    ctrl_case(8'h01, 4'b1111, "R8 enable without assert");
    ctrl_case(8'h02, 4'b1111, "R8 assert without enable");
    ctrl_case(8'hC3, 4'b0110, "R8 chips 0 and 3");
    ctrl_case(8'h3C, 4'b1001, "R8 chips 1 and 2");
    ctrl_case(8'h00, 4'b1111, "R9 zero clears all");
  endtask

  task automatic t_ready_busy();
    logic [31:0] q;
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    nand_rb = 0;
    host_req = 1; host_reg_sel = 1; host_we = 0; host_addr = 17'h4;
    @(negedge clk);
    host_req = 0;
    check("R10 first read keeps old level", host_rdata, 32'd1);
    reg_read(17'h4, q);
    check("R10 second read sees busy", q, 32'd0);
    nand_rb = 1;
    repeat (3) @(negedge clk);
    reg_read(17'h4, q);
    check("R10 ready again", q, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_cycles();
    t_width();
    t_chips();
    t_ready_busy();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule